// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire link to a 12-bit successive-approximation converter. When a start request is accepted it pulls the active-low convert line down, which begins a conversion. It then produces sixteen serial clock periods from a divided system clock, shifts the converter's data line into a frame register, and presents the 12-bit code as a parallel word with a one-cycle valid strobe.

The sixteen-bit frame holds three leading zeros, the twelve result bits with the most significant bit first, and one trailing zero. The converter changes its data line on serial clock rising edges. The controller samples on the rising edge when clock polarity equals clock phase, and on the falling edge otherwise. Both are set by parameters. A static input selects straight-binary coding (zero-extended to 16 bits) or two's-complement coding (sign-extended to 16 bits). Any nonzero padding bit raises a framing-error flag for that result. A busy flag covers each transaction.

The half period of the serial clock is derived when the design is elaborated from the system clock rate and the highest permitted serial clock rate (28.8 MHz by default). A parameter can raise it further.

Top module: `serial_adc_reader`

## Requirements
- R1: Out of reset and whenever busy is low, the convert line is high, the serial clock rests at the CPOL level, and valid is low. Result and framing error reset to zero.
- R2: When start is sampled high while the block is idle and valid is low, the convert line goes low and busy goes high at the next clock edge.
- R3: Each transaction produces exactly 16 serial clock periods. The last edge returns the clock to its CPOL level in the same cycle that the convert line goes high and valid pulses.
- R4: Data is sampled on the rising serial edge when CPOL equals CPHA, and on the falling edge otherwise. The k-th sampling edge (k = 0..15) yields frame bit k. Frame bits 3 to 14 form the code, with bit 3 as the code MSB.
- R5: With bipolar_i low, result bits 11:0 carry the code and bits 15:12 are zero.
- R6: With bipolar_i high, the code is two's complement and bits 15:12 copy code bit 11 (code 0x800 gives 0xF800, code 0x7FF gives 0x07FF).
- R7: frame_err_o is updated together with valid. It is 1 when frame bit 0, 1, 2 or 15 was 1, and 0 otherwise.
- R8: A start request received while busy is high is ignored and causes no second convert-line falling edge.
- R9: Busy is high on every cycle from the convert-line falling edge up to the cycle before valid, and low in the valid cycle.
- R10: Valid lasts exactly one cycle. Result and frame_err_o hold their values until the next valid.
- R11: Even when start is held high continuously, the convert line stays high for at least one full system clock cycle between transactions.
- R12: Each serial clock level lasts max(HALF_DIV_MIN, ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ))) system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request |
| bipolar_i | input | 1 | Static coding select: 1 = two's complement, 0 = straight binary |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_n_o | output | 1 | Active-low convert line |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | OUT_W | Zero- or sign-extended result |
| frame_err_o | output | 1 | Padding bit of the last frame was nonzero |

## Verification
The bench builds two copies side by side. One uses CPOL=0, CPHA=0 and a derived half period of one cycle, which is the fastest legal serial clock at 50 MHz. The other uses CPOL=1, CPHA=0 with HALF_DIV_MIN=3, so sampling happens on falling edges and the divider counter runs over several cycles. Together they cover both sampling-edge choices, both clock idle levels, and a last edge that is rising in one copy and falling in the other. The converter model can inject nonzero padding bits to exercise the framing-error flag.

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
module serial_adc_reader #(
  parameter int CPOL         = 0,
  parameter int CPHA         = 0,
  parameter int DATA_W       = 12,
  parameter int OUT_W        = 16,
  parameter int SYS_CLK_HZ   = 50_000_000,
  parameter int SCLK_MAX_HZ  = 28_800_000,
  parameter int HALF_DIV_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bipolar_i,
  input  logic             sdo_i,
  output logic             cnv_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o,
  output logic             frame_err_o
);
  localparam int   FRAME_W   = DATA_W + 4;
  localparam int   TOGGLES   = 2 * FRAME_W;
  localparam int   HALF_CALC = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int   HALF_DIV  = (HALF_CALC > HALF_DIV_MIN) ? HALF_CALC : HALF_DIV_MIN;
  localparam int   DIV_W     = $clog2(HALF_DIV + 1);
  localparam int   TOG_W     = $clog2(TOGGLES + 1);
  localparam logic CAP_LVL   = (CPOL == CPHA);
  localparam logic IDLE_LVL  = 1'(CPOL);

  logic [DIV_W-1:0]   div_q;
  logic [TOG_W-1:0]   tog_q;
  logic [FRAME_W-1:0] sr_q;

  wire tick = busy_o && (div_q == DIV_W'(HALF_DIV - 1));
  wire cap  = tick && ((~sclk_o) == CAP_LVL);
  wire last = tick && (tog_q == TOG_W'(TOGGLES - 1));

  wire [FRAME_W-1:0] sr_nx = cap ? {sr_q[FRAME_W-2:0], sdo_i} : sr_q;
  wire [DATA_W-1:0]  code  = sr_nx[DATA_W:1];
  wire               ferr  = (|sr_nx[FRAME_W-1:FRAME_W-3]) | sr_nx[0];
  wire [OUT_W-1:0]   ext   = {{(OUT_W-DATA_W){bipolar_i & code[DATA_W-1]}}, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      cnv_n_o     <= 1'b1;
      sclk_o      <= IDLE_LVL;
      valid_o     <= 1'b0;
      result_o    <= '0;
      frame_err_o <= 1'b0;
      div_q       <= '0;
      tog_q       <= '0;
      sr_q        <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!busy_o && !valid_o && start_i) begin
        busy_o  <= 1'b1;
        cnv_n_o <= 1'b0;
        div_q   <= '0;
        tog_q   <= '0;
        sr_q    <= '0;
      end else if (busy_o) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        sr_q  <= sr_nx;
        if (tick) begin
          sclk_o <= ~sclk_o;
          tog_q  <= tog_q + 1'b1;
        end
        if (last) begin
          busy_o      <= 1'b0;
          cnv_n_o     <= 1'b1;
          valid_o     <= 1'b1;
          result_o    <= ext;
          frame_err_o <= ferr;
        end
      end
    end
  end
endmodule

// File: rtl/serial_adc_reader_chk.sv
`timescale 1ns/1ps
module serial_adc_reader_chk #(
  parameter int CPOL   = 0,
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             bipolar_i,
  input logic             cnv_n_o,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] result_o,
  input logic             frame_err_o
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cnv_n_o && sclk_o == 1'(CPOL))); // R1
  AST_START_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n_o) |-> ($past(start_i) && busy_o)); // R2
  AST_RELEASE_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($rose(cnv_n_o) && sclk_o == 1'(CPOL))); // R3
  AST_UNI_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !bipolar_i) |-> (result_o[OUT_W-1:DATA_W] == '0)); // R5
  AST_BIP_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && bipolar_i) |-> (result_o[OUT_W-1:DATA_W] == {(OUT_W-DATA_W){result_o[DATA_W-1]}})); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> !$fell(cnv_n_o)); // R8
  AST_BUSY_ENDS_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(frame_err_o))); // R10
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n_o) |=> cnv_n_o); // R11
endmodule

bind serial_adc_reader serial_adc_reader_chk #(
  .CPOL(CPOL), .DATA_W(DATA_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bipolar_i(bipolar_i),
  .cnv_n_o(cnv_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .valid_o(valid_o),
  .result_o(result_o), .frame_err_o(frame_err_o)
);

// File: tb/tb_serial_adc_reader.sv
`timescale 1ns/1ps
module rd_lane #(
  parameter int CPOL = 0,
  parameter int CPHA = 0,
  parameter int HMIN = 1,
  parameter int HEXP = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bipolar,
  input  logic [15:0] frame,
  output logic        cnv_n,
  output logic        sclk,
  output logic        busy,
  output logic        valid,
  output logic [15:0] result,
  output logic        ferr
);
  localparam logic CAP_LVL = (CPOL == CPHA);
  logic sdata = 1'b1;
  logic ps, pc;
  int caps = 0, rises = 0;
  int vcount = 0, vlong = 0, bbad = 0, falls = 0, bad_runs = 0;
  int runlen = 0, hi = 0, last_gap = 0;
  logic prev_busy = 1'b0, prev_valid = 1'b0, prev_cnv = 1'b1, prev_sclk = 1'(CPOL);

  serial_adc_reader #(.CPOL(CPOL), .CPHA(CPHA), .HALF_DIV_MIN(HMIN)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bipolar_i(bipolar), .sdo_i(sdata),
    .cnv_n_o(cnv_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
    .result_o(result), .frame_err_o(ferr));

  // converter model: bit k is on the line at the k-th sampling edge, updates on rising edges
  always @(sclk or cnv_n) begin
    if (cnv_n !== pc) begin
      pc = cnv_n;
      if (cnv_n === 1'b0) begin
        caps = 0; rises = 0;
        sdata <= #1 frame[15];
      end else sdata <= #1 1'b1;
    end
    if (sclk !== ps) begin
      ps = sclk;
      if (sclk === 1'b1) rises++;
      if (sclk === CAP_LVL) caps++;
      if (sclk === 1'b1) sdata <= #1 (caps < 16) ? frame[15-caps] : 1'b0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (valid) begin
      vcount++;
      if (prev_valid) vlong++;
      if (busy || !prev_busy) bbad++;
    end
    if (!cnv_n && prev_cnv) begin falls++; last_gap = hi; end
    if (cnv_n) hi = prev_cnv ? hi + 1 : 1;
    if (busy && !prev_busy) runlen = 1;
    else if (sclk !== prev_sclk) begin
      if (prev_busy && runlen != HEXP) bad_runs++;
      runlen = 1;
    end else runlen++;
    prev_busy = busy; prev_valid = valid; prev_cnv = cnv_n; prev_sclk = sclk;
  end
endmodule

module tb_serial_adc_reader;
  localparam int H0 = 1;  // max(1, ceil(50e6/57.6e6))
  localparam int H1 = 3;  // max(3, 1)
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bipolar = 1'b0;
  logic [15:0] frame = 16'h0;
  int nchk = 0, nfail = 0;

  logic cn0, sc0, bz0, vl0, fe0, cn1, sc1, bz1, vl1, fe1;
  logic [15:0] rs0, rs1;

  always #10 clk = ~clk;

  rd_lane #(.CPOL(0), .CPHA(0), .HMIN(1), .HEXP(H0)) lane0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar), .frame(frame),
    .cnv_n(cn0), .sclk(sc0), .busy(bz0), .valid(vl0), .result(rs0), .ferr(fe0));
  rd_lane #(.CPOL(1), .CPHA(0), .HMIN(3), .HEXP(H1)) lane1 (
    .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar), .frame(frame),
    .cnv_n(cn1), .sclk(sc1), .busy(bz1), .valid(vl1), .result(rs1), .ferr(fe1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic wait_both(input int v0, input int v1);
    int n = 0;
    while ((lane0.vcount <= v0 || lane1.vcount <= v1) && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(n < 2000, "R3 transaction completes", n, 0);
  endtask

  task automatic run_frame(input logic [15:0] fr, input logic bip, input string tag);
    int v0 = lane0.vcount, v1 = lane1.vcount;
    logic [11:0] code = fr[12:1];
    logic [15:0] expv = bip ? {{4{code[11]}}, code} : {4'b0, code};
    logic expe = fr[15] | fr[14] | fr[13] | fr[0];
    frame = fr; bipolar = bip;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!cn0 && bz0 && !cn1 && bz1, {"R2 start ", tag}, {cn0, bz0, cn1, bz1}, 4'b0101);
    wait_both(v0, v1);
    @(negedge clk);
    chk(rs0 == expv, {"R4/R5/R6 lane0 ", tag}, rs0, expv);
    chk(rs1 == expv, {"R4/R5/R6 lane1 ", tag}, rs1, expv);
    chk(fe0 == expe && fe1 == expe, {"R7 ", tag}, {fe0, fe1}, {expe, expe});
    chk(lane0.rises == 16 && lane1.rises == 16, {"R3 ", tag}, lane0.rises * 256 + lane1.rises, 16 * 256 + 16);
    chk(lane0.bad_runs == 0 && lane1.bad_runs == 0, {"R12 ", tag}, lane0.bad_runs + lane1.bad_runs, 0);
    chk(lane0.vlong == 0 && lane1.vlong == 0, {"R10 ", tag}, lane0.vlong + lane1.vlong, 0);
    chk(lane0.bbad == 0 && lane1.bbad == 0, {"R9 ", tag}, lane0.bbad + lane1.bbad, 0);
  endtask

  task automatic t_reset();
    chk(cn0 && cn1 && !bz0 && !bz1 && !vl0 && !vl1, "R1 idle lines", {cn0, cn1, bz0, bz1, vl0, vl1}, 6'b110000);
    chk(sc0 == 1'b0 && sc1 == 1'b1, "R1 clock idle level", {sc0, sc1}, 2'b01);
    chk(rs0 == 0 && rs1 == 0 && !fe0 && !fe1, "R1 cleared outputs", rs0 | rs1, 0);
    chk(50_000_000 / (2 * H0) <= 28_800_000 && 50_000_000 / (2 * H1) <= 28_800_000, "R12 rate bound", H0, H1);
  endtask

  task automatic t_unipolar();
    run_frame({3'b000, 12'h000, 1'b0}, 1'b0, "uni zero");
    run_frame({3'b000, 12'hFFF, 1'b0}, 1'b0, "uni full");
    run_frame({3'b000, 12'hA5C, 1'b0}, 1'b0, "uni mixed");
  endtask

  task automatic t_bipolar();
    run_frame({3'b000, 12'h800, 1'b0}, 1'b1, "bip neg full");
    run_frame({3'b000, 12'h7FF, 1'b0}, 1'b1, "bip pos full");
    run_frame({3'b000, 12'h123, 1'b0}, 1'b1, "bip small");
  endtask

  task automatic t_framing();
    run_frame({3'b100, 12'h3C3, 1'b0}, 1'b0, "lead bit0 set");
    run_frame({3'b001, 12'h0F0, 1'b0}, 1'b1, "lead bit2 set");
    run_frame({3'b000, 12'h555, 1'b1}, 1'b0, "trail set");
    run_frame({3'b000, 12'h555, 1'b0}, 1'b0, "clean after error");
  endtask

  task automatic t_busy_ignore();
    int f0 = lane0.falls, f1 = lane1.falls, v0 = lane0.vcount, v1 = lane1.vcount;
    frame = {3'b000, 12'h9A6, 1'b0}; bipolar = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_both(v0, v1);
    repeat (120) @(negedge clk);
    chk(lane0.falls - f0 == 1 && lane1.falls - f1 == 1, "R8 single convert edge",
        (lane0.falls - f0) * 16 + (lane1.falls - f1), 16 + 1);
    chk(lane0.vcount - v0 == 1 && lane1.vcount - v1 == 1, "R8 single result",
        (lane0.vcount - v0) * 16 + (lane1.vcount - v1), 16 + 1);
    chk(!bz0 && !bz1 && rs0 == 16'h09A6, "R8 idle afterwards", rs0, 16'h09A6);
  endtask

  task automatic t_hold();
    logic [15:0] r0 = rs0, r1 = rs1;
    logic e0 = fe0, e1 = fe1;
    frame = 16'hFFFF; bipolar = ~bipolar;
    repeat (40) @(negedge clk);
    chk(rs0 == r0 && rs1 == r1 && fe0 == e0 && fe1 == e1, "R10 result held", rs0, r0);
    bipolar = 1'b0;
  endtask

  task automatic t_back_to_back();
    int v0 = lane0.vcount, v1 = lane1.vcount, n = 0;
    frame = {3'b000, 12'h6B1, 1'b0}; bipolar = 1'b0;
    @(negedge clk); start = 1'b1;
    while ((lane0.vcount < v0 + 2 || lane1.vcount < v1 + 2) && n < 3000) begin
      @(negedge clk); n++;
    end
    start = 1'b0;
    repeat (120) @(negedge clk);
    chk(lane0.last_gap >= 1 && lane1.last_gap >= 1, "R11 idle gap", lane0.last_gap * 16 + lane1.last_gap, 16 + 1);
    chk(rs0 == 16'h06B1 && rs1 == 16'h06B1, "R4 back to back data", rs0, 16'h06B1);
    chk(lane0.vlong == 0 && lane1.vlong == 0 && !bz0 && !bz1, "R10 pulse width", lane0.vlong + lane1.vlong, 0);
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_unipolar();
    t_bipolar();
    t_framing();
    t_busy_ignore();
    t_hold();
    t_back_to_back();
    summary();
  end
endmodule